// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a 16-bit processor's memory address register and a 512 KB RAM. When paging is on, it maps each logical address to a 19-bit physical address through a 256-entry page table. The table is split into eight fixed windows of 32 entries each. A base register picks the window that belongs to the running address space. Software changes the current address space by rewriting the base register and edits mappings by writing single table entries.

Each logical address has two parts. The upper five bits are a page number, and the base register is added to it to form an 8-bit table index. The lower eleven bits are a byte offset inside a 2 KB page. The physical address is the upper byte of the selected entry, followed by the unchanged offset. When paging is off, the logical address goes to memory untouched, zero-extended, so only the lowest 64 KB can be reached.

Translation is purely combinational. Both write ports act on the rising clock edge. The two write ports are plain strobes that are always accepted, so there is no back-pressure anywhere in the block. The table has no reset; only the base register is cleared.

Top module: `page_xlate`

## Requirements
- R1: An active-low asynchronous reset clears the base register to 0. It leaves the page table contents untouched.
- R2: With `xl_en` low, `phys_addr` equals `log_addr` zero-extended to 19 bits. Neither the table nor the base is consulted.
- R3: With `xl_en` high, `phys_addr[10:0]` equals `log_addr[10:0]` and `phys_addr[18:11]` equals bits 15:8 of the selected entry.
- R4: The selected entry index is (base + `log_addr[15:11]`) modulo 256. A sum above 255 wraps around and raises no fault.
- R5: Bits 7:0 of a table entry have no effect on the translated address.
- R6: A write with `ent_we` high stores `ent_data` at index `ent_idx` on the rising clock edge. The output changes only after that edge. No other entry changes.
- R7: A write with `base_we` high loads `base_data` into the base register on the rising clock edge. Without that strobe the base holds its value.
- R8: An entry write and a base write in the same cycle both take effect at that edge.
- R9: Turning `xl_en` off and back on leaves the mapping unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both write ports act on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset for the base register |
| xl_en | input | 1 | Paging enable; low selects the bypass path |
| log_addr | input | 16 | Logical address from the processor |
| ent_we | input | 1 | Page table entry write strobe |
| ent_idx | input | 8 | Index of the entry to write |
| ent_data | input | 16 | Entry value; the physical page number is in bits 15:8 |
| base_we | input | 1 | Base register write strobe |
| base_data | input | 8 | New base value; a multiple of 32 for a normal address space |
| phys_addr | output | 19 | Physical address to memory |

## Verification
The hardest case to reach is the index wrap. It needs a base value that is not a multiple of 32 together with a high page number, which normal software never produces. The stimulus table writes a base of 240 and presents page 31, so the index lands on entry 15.

Write timing is the other subtle case, because the translation is combinational. The bench holds a logical address fixed while a write strobe is active. It samples the output once before the write edge, expecting the old mapping, and once after it, expecting the new one. It also checks the neighbouring entry and the base value across a mid-run reset.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  localparam int unsigned LA_W   = 16;
  localparam int unsigned OFF_W  = 11;
  localparam int unsigned PPN_W  = 8;
  localparam int unsigned ENT_W  = 16;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned PAGE_W = LA_W - OFF_W;
  localparam int unsigned PA_W   = PPN_W + OFF_W;
endpackage

// File: rtl/page_xlate_table.sv
module page_xlate_table #(
  parameter int unsigned IDX_W = page_xlate_pkg::IDX_W,
  parameter int unsigned ENT_W = page_xlate_pkg::ENT_W,
  parameter int unsigned PPN_W = page_xlate_pkg::PPN_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PPN_W-1:0] rd_ppn
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  // Only the page-number field is kept; the low bits never reach the output.
  logic [PPN_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data[ENT_W-1 -: PPN_W];
  end

  assign rd_ppn = mem[rd_idx];
endmodule

// File: rtl/page_xlate_index.sv
module page_xlate_index #(
  parameter int unsigned IDX_W  = page_xlate_pkg::IDX_W,
  parameter int unsigned PAGE_W = page_xlate_pkg::PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [IDX_W-1:0]  base_data,
  input  logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  base_q,
  output logic [IDX_W-1:0]  idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_data;
  end

  // Sum truncated to IDX_W bits: wraps modulo the table depth.
  assign idx = base_q + IDX_W'(page);
endmodule

// File: rtl/page_xlate_compose.sv
module page_xlate_compose #(
  parameter int unsigned LA_W  = page_xlate_pkg::LA_W,
  parameter int unsigned OFF_W = page_xlate_pkg::OFF_W,
  parameter int unsigned PPN_W = page_xlate_pkg::PPN_W,
  parameter int unsigned PA_W  = page_xlate_pkg::PA_W
) (
  input  logic             en,
  input  logic [LA_W-1:0]  log_addr,
  input  logic [PPN_W-1:0] ppn,
  output logic [PA_W-1:0]  phys_addr
);
  logic [PA_W-1:0] bypass;
  logic [PA_W-1:0] mapped;

  generate
    if (PA_W > LA_W) begin : g_ext
      assign bypass = {{(PA_W-LA_W){1'b0}}, log_addr};
    end else begin : g_trunc
      assign bypass = log_addr[PA_W-1:0];
    end
  endgenerate

  assign mapped    = {ppn, log_addr[OFF_W-1:0]};
  assign phys_addr = en ? mapped : bypass;
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xl_en,
  input  logic [LA_W-1:0]  log_addr,
  input  logic             ent_we,
  input  logic [IDX_W-1:0] ent_idx,
  input  logic [ENT_W-1:0] ent_data,
  input  logic             base_we,
  input  logic [IDX_W-1:0] base_data,
  output logic [PA_W-1:0]  phys_addr
);
  logic [IDX_W-1:0] base_q;
  logic [IDX_W-1:0] rd_idx;
  logic [PPN_W-1:0] ppn;

  page_xlate_index #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_index (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_we  (base_we),
    .base_data(base_data),
    .page     (log_addr[LA_W-1:OFF_W]),
    .base_q   (base_q),
    .idx      (rd_idx)
  );

  page_xlate_table #(.IDX_W(IDX_W), .ENT_W(ENT_W), .PPN_W(PPN_W)) u_table (
    .clk    (clk),
    .we     (ent_we),
    .wr_idx (ent_idx),
    .wr_data(ent_data),
    .rd_idx (rd_idx),
    .rd_ppn (ppn)
  );

  page_xlate_compose #(.LA_W(LA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .PA_W(PA_W)) u_compose (
    .en       (xl_en),
    .log_addr (log_addr),
    .ppn      (ppn),
    .phys_addr(phys_addr)
  );
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk
  import page_xlate_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             xl_en,
  input logic [LA_W-1:0]  log_addr,
  input logic             ent_we,
  input logic             base_we,
  input logic [IDX_W-1:0] base_data,
  input logic [IDX_W-1:0] base_q,
  input logic [PA_W-1:0]  phys_addr
);
  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_en |-> (phys_addr == PA_W'(log_addr))); // R2

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    xl_en |-> (phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0])); // R3

  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> (base_q == $past(base_data))); // R7

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !base_we |=> $stable(base_q)); // R7

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!ent_we && !base_we) && $stable(log_addr) && $stable(xl_en))
      |-> $stable(phys_addr)); // R6
endmodule

bind page_xlate page_xlate_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .xl_en    (xl_en),
  .log_addr (log_addr),
  .ent_we   (ent_we),
  .base_we  (base_we),
  .base_data(base_data),
  .base_q   (base_q),
  .phys_addr(phys_addr)
);

// File: tb/sim_page_xlate.sv
module sim_page_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xl_en = 1'b0;
  logic [15:0] log_addr = '0;
  logic        ent_we = 1'b0;
  logic [7:0]  ent_idx = '0;
  logic [15:0] ent_data = '0;
  logic        base_we = 1'b0;
  logic [7:0]  base_data = '0;
  logic [18:0] phys_addr;

  int total = 0;
  int bad = 0;
  logic [15:0] shadow [256];
  logic [7:0]  cur_base = '0;

  always #5 clk = ~clk;

  page_xlate u0 (.*);

  // {base[7:0], enable, logical address[15:0]}
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {8'd0,   1'b1, 16'h0000},
    {8'd0,   1'b1, 16'hFFFF},
    {8'd32,  1'b1, 16'h0800},
    {8'd224, 1'b1, 16'hF8AB},
    {8'd96,  1'b0, 16'h1234},
    {8'd160, 1'b1, 16'h5A5A},
    {8'd240, 1'b1, 16'hF801},
    {8'd64,  1'b1, 16'h07FF}
  };

  function automatic logic [18:0] model(input logic [7:0] b, input logic e, input logic [15:0] a);
    logic [7:0] ix;
    ix = b + {3'b000, a[15:11]};
    return e ? {shadow[ix][15:8], a[10:0]} : {3'b000, a};
  endfunction

  task automatic chk(input string req, input logic [18:0] act, input logic [18:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ent(input logic [7:0] i, input logic [15:0] v);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = i; ent_data = v;
    @(negedge clk);
    ent_we = 1'b0;
    shadow[i] = v;
  endtask

  task automatic wr_base(input logic [7:0] v);
    @(negedge clk);
    base_we = 1'b1; base_data = v;
    @(negedge clk);
    base_we = 1'b0;
    cur_base = v;
  endtask

  task automatic drive(input logic e, input logic [15:0] a);
    @(negedge clk);
    xl_en = e; log_addr = a;
    #1;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) wr_ent(8'(i), {8'(i) ^ 8'hA5, 8'(i)});

    // R1: base starts at 0 after reset, page 6 -> entry 6
    drive(1'b1, 16'h3000);
    chk("R1 reset base", phys_addr, {8'hA3, 11'h000});

    // stimulus table
    for (int k = 0; k < NV; k++) begin
      wr_base(VEC[k][24:17]);
      drive(VEC[k][16], VEC[k][15:0]);
      chk(VEC[k][16] ? "R3 R4 mapped" : "R2 bypass", phys_addr,
          model(VEC[k][24:17], VEC[k][16], VEC[k][15:0]));
    end

    // R4: wrap 240 + 31 = 271 -> entry 15
    wr_base(8'd240);
    drive(1'b1, 16'hF955);
    chk("R4 wrap", phys_addr, {8'h0F ^ 8'hA5, 11'h155});

    // R6: write visible only after its edge, neighbour untouched
    wr_base(8'd32);
    drive(1'b1, 16'h4000);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = 8'd40; ent_data = 16'h7E00;
    #1;
    chk("R6 before edge", phys_addr, {8'd40 ^ 8'hA5, 11'h000});
    @(negedge clk);
    ent_we = 1'b0; shadow[40] = 16'h7E00;
    #1;
    chk("R6 after edge", phys_addr, {8'h7E, 11'h000});
    drive(1'b1, 16'h4800);
    chk("R6 neighbour", phys_addr, {8'd41 ^ 8'hA5, 11'h000});

    // R5: low byte of an entry is ignored
    wr_ent(8'd41, 16'h19C3);
    drive(1'b1, 16'h4ABC);
    chk("R5 low byte a", phys_addr, {8'h19, 11'h2BC});
    wr_ent(8'd41, 16'h1900);
    #1;
    chk("R5 low byte b", phys_addr, {8'h19, 11'h2BC});

    // R7: base write timing
    drive(1'b1, 16'h0000);
    @(negedge clk);
    base_we = 1'b1; base_data = 8'd64;
    #1;
    chk("R7 before edge", phys_addr, {shadow[32][15:8], 11'h000});
    @(negedge clk);
    base_we = 1'b0; cur_base = 8'd64;
    #1;
    chk("R7 after edge", phys_addr, {shadow[64][15:8], 11'h000});

    // R8: simultaneous writes
    @(negedge clk);
    base_we = 1'b1; base_data = 8'd128;
    ent_we = 1'b1; ent_idx = 8'd130; ent_data = 16'hC000;
    @(negedge clk);
    base_we = 1'b0; ent_we = 1'b0;
    shadow[130] = 16'hC000; cur_base = 8'd128;
    drive(1'b1, 16'h1000);
    chk("R8 both writes", phys_addr, {8'hC0, 11'h000});

    // R9: enable toggle keeps mapping; R2 full-range bypass
    drive(1'b0, 16'h1000);
    chk("R9 off", phys_addr, 19'h01000);
    drive(1'b0, 16'hFFFF);
    chk("R2 top of 64K", phys_addr, 19'h0FFFF);
    drive(1'b1, 16'h1000);
    chk("R9 back on", phys_addr, {8'hC0, 11'h000});

    // R1: mid-run reset clears base, table kept
    wr_base(8'd96);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, 16'h0000);
    chk("R1 reset again", phys_addr, {8'hA5, 11'h000});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule